// File: doc/BRIEF.md
# Configurable Logic Slice

A model of one programmable logic slice. It holds four lookup tables of six inputs each, two first-level combining multiplexers, one second-level combining multiplexer and four flip-flops. A serial shift chain, written while a configuration-enable input is high, holds every truth-table bit and every per-path mode bit. The slice is loaded once and then used as ordinary logic.

Each lookup table gives two results from its two stored 32-bit halves. The 5-input result reads the lower half, addressed by the five low inputs. The 6-input result uses the top input to choose between the two halves. Three bypass inputs steer the combining multiplexers. They join table pairs into 7-input functions and the two pairs into one 8-input function.

Each of the four output paths has its own mode. The mode picks the path's source: the 6-input result, the 5-input result, a wide result, or the path's bypass input, which turns the flip-flop into a standalone register. The mode also chooses whether the path shows that source directly or through its flip-flop. A clock enable and a synchronous clear act on all four flip-flops together.

Top module: `clb_slice`

## Requirements
- R1: With table k loaded with bits T[63:0], the 6-input result of table k equals T[a], where a is the 6-bit field `lut_in[6k+5:6k]`.
- R2: `o5_out[k]` equals T[{0, a[4:0]}], the lower-half bit addressed by the five low inputs, whatever the value of a[5].
- R3: The first-level pair results are W0 = `bypass[0]` ? R6(1) : R6(0) and W2 = `bypass[2]` ? R6(3) : R6(2). Here R6(k) is the 6-input result of table k.
- R4: The second-level result is W1 = `bypass[1]` ? W2 : W0.
- R5: The 2-bit source code of path k selects 0: R6(k), 1: the 5-input result of table k, 2: the wide result, 3: `bypass[k]`. The wide result is W0, W1, W2 and W1 for paths 0, 1, 2 and 3.
- R6: When the registered bit of path k is 1, `path_out[k]` shows the path's flip-flop. When it is 0, `path_out[k]` shows the selected source in the same cycle.
- R7: On a rising edge with `clk_en` high, each flip-flop captures its path's selected source. With `clk_en` low it holds its value.
- R8: `sync_clr` high clears all four flip-flops on the next rising edge, whatever `clk_en` is.
- R9: While `cfg_en` is high, `path_out` and `o5_out` read 0. Each rising edge shifts `cfg_in` into chain position 0 and clears the flip-flops.
- R10: The chain is 268 bits. Bit 64k+b is T[b] of table k. Bits 256+3k+1..256+3k hold the source code of path k, and bit 256+3k+2 holds its registered bit. Bits enter at position 0, so the bit shifted in first ends at position 267. `cfg_out` shows position 267. With `cfg_en` low the chain keeps its contents.
- R11: `rst_n` low clears the chain and the flip-flops at once, without a clock edge, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data |
| cfg_out | output | 1 | Top bit of the configuration chain |
| lut_in | input | 24 | Six inputs per table, table k at bits 6k+5..6k |
| bypass | input | 4 | Combining-multiplexer selects and standalone register data |
| clk_en | input | 1 | Flip-flop clock enable |
| sync_clr | input | 1 | Synchronous clear of all flip-flops |
| path_out | output | 4 | Per-path output, combinational or registered |
| o5_out | output | 4 | 5-input result of each table |

## Verification
The combinational outputs `path_out` (in direct mode) and `o5_out` settle in the cycle their inputs change. The bench therefore drives inputs on the falling edge and compares 2 ns later, within the same cycle. A registered path shows its new value after the following rising edge. The reference model updates its flip-flop state at that edge, using the values that were driven before it. The configuration-chain output is checked before each shift, against the bit of the previous load that should have reached the top position by then.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;
  typedef enum logic [1:0] {
    SRC_LUT6 = 2'd0,
    SRC_LUT5 = 2'd1,
    SRC_WIDE = 2'd2,
    SRC_BYP  = 2'd3
  } src_e;

  typedef struct packed {
    logic use_reg;
    src_e src;
  } path_mode_t;

  localparam int unsigned MODE_W = $bits(path_mode_t);
endpackage

// File: rtl/clb_rst_sync.sv
`timescale 1ns/1ps
module clb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/clb_cfg_chain.sv
`timescale 1ns/1ps
module clb_cfg_chain #(
  parameter int unsigned WIDTH = 268
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] cfg_o,
  output logic             dout_o
);
  logic [WIDTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_i) sr_d = {sr_q[WIDTH-2:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign cfg_o  = sr_q;
  assign dout_o = sr_q[WIDTH-1];

  // R10: contents stay put while shifting is off
  a_r10_chain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
  // R9: a shift takes the serial bit into position 0
  a_r9_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[0] == $past(din_i));
endmodule

// File: rtl/clb_lut.sv
`timescale 1ns/1ps
module clb_lut #(
  parameter int unsigned K = 6
) (
  input  logic [(1<<K)-1:0] tt_i,
  input  logic [K-1:0]      sel_i,
  output logic              o6_o,
  output logic              o5_o
);
  localparam int unsigned HALF = 1 << (K - 1);

  logic [1:0] half_bit;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF-1:0] store;
    assign store       = tt_i[h*HALF +: HALF];
    assign half_bit[h] = store[sel_i[K-2:0]];
  end

  assign o5_o = half_bit[0];
  assign o6_o = sel_i[K-1] ? half_bit[1] : half_bit[0];
endmodule

// File: rtl/clb_path.sv
`timescale 1ns/1ps
module clb_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_en_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic d_i,
  input  logic use_reg_i,
  output logic out_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (cfg_en_i || clr_i) q_d = 1'b0;
    else if (en_i)         q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign out_o = cfg_en_i ? 1'b0 : (use_reg_i ? q_q : d_i);

  // R9: configuration clears the register
  a_r9_cfg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !q_q);
  // R8: synchronous clear wins over enable
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cfg_en_i) |=> !q_q);
  // R7: capture with enable
  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !cfg_en_i) |=> q_q == $past(d_i));
  // R7: hold without enable
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && !cfg_en_i) |=> $stable(q_q));
endmodule

// File: rtl/clb_slice.sv
`timescale 1ns/1ps
module clb_slice #(
  parameter int unsigned LUT_IN = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_in,
  output logic                 cfg_out,
  input  logic [4*LUT_IN-1:0]  lut_in,
  input  logic [3:0]           bypass,
  input  logic                 clk_en,
  input  logic                 sync_clr,
  output logic [3:0]           path_out,
  output logic [3:0]           o5_out
);
  import clb_pkg::*;

  localparam int unsigned N_LUT = 4;
  localparam int unsigned TT_W  = 1 << LUT_IN;
  localparam int unsigned TT_SZ = N_LUT * TT_W;
  localparam int unsigned CFG_W = TT_SZ + N_LUT * MODE_W;

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg;
  logic [N_LUT-1:0] o6, o5, wide, src_val;
  logic             f7_lo, f7_hi, f8;
  path_mode_t       mode [N_LUT];

  clb_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk), .rst_ni(rst_n), .rst_sync_no(rst_sync_n)
  );

  clb_cfg_chain #(.WIDTH(CFG_W)) u_chain (
    .clk_i(clk), .rst_ni(rst_sync_n), .shift_i(cfg_en), .din_i(cfg_in),
    .cfg_o(cfg), .dout_o(cfg_out)
  );

  assign f7_lo = bypass[0] ? o6[1] : o6[0];
  assign f7_hi = bypass[2] ? o6[3] : o6[2];
  assign f8    = bypass[1] ? f7_hi : f7_lo;
  assign wide  = {f8, f7_hi, f8, f7_lo};

  for (genvar k = 0; k < N_LUT; k++) begin : g_path
    assign mode[k] = path_mode_t'(cfg[TT_SZ + k*MODE_W +: MODE_W]);

    clb_lut #(.K(LUT_IN)) u_lut (
      .tt_i (cfg[k*TT_W +: TT_W]),
      .sel_i(lut_in[k*LUT_IN +: LUT_IN]),
      .o6_o (o6[k]),
      .o5_o (o5[k])
    );

    always_comb begin
      unique case (mode[k].src)
        SRC_LUT6: src_val[k] = o6[k];
        SRC_LUT5: src_val[k] = o5[k];
        SRC_WIDE: src_val[k] = wide[k];
        default:  src_val[k] = bypass[k];
      endcase
    end

    clb_path u_path (
      .clk_i    (clk),
      .rst_ni   (rst_sync_n),
      .cfg_en_i (cfg_en),
      .clr_i    (sync_clr),
      .en_i     (clk_en),
      .d_i      (src_val[k]),
      .use_reg_i(mode[k].use_reg),
      .out_o    (path_out[k])
    );

    assign o5_out[k] = cfg_en ? 1'b0 : o5[k];

    // R2: with the top input low both table results agree
    a_r2_halves_agree: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!cfg_en && !lut_in[k*LUT_IN + LUT_IN - 1]) |-> o5_out[k] == o6[k]);
    // R6: direct mode shows the selected source
    a_r6_direct: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!cfg_en && !mode[k].use_reg) |-> path_out[k] == src_val[k]);
  end

  // R9: outputs quiet while configuring
  a_r9_outs_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_en |-> (path_out == '0 && o5_out == '0));
endmodule

// File: tb/sim_clb_slice.sv
`timescale 1ns/1ps
module sim_clb_slice;
  logic        clk = 1'b0;
  logic        rst_n, cfg_en, cfg_in, clk_en, sync_clr;
  logic [23:0] lut_in;
  logic [3:0]  bypass;
  logic        cfg_out;
  logic [3:0]  path_out, o5_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0]  tt_m   [4];
  logic [1:0]   src_m  [4];
  logic         ureg_m [4];
  logic         q_m    [4];
  logic [267:0] cfg_old;

  always #10 clk = ~clk;

  clb_slice u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .lut_in(lut_in), .bypass(bypass), .clk_en(clk_en), .sync_clr(sync_clr),
    .path_out(path_out), .o5_out(o5_out)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic r6m(int k, logic [23:0] vin);
    logic [5:0] a;
    a = vin[k*6 +: 6];
    return tt_m[k][a];
  endfunction

  function automatic logic r5m(int k, logic [23:0] vin);
    logic [5:0] a;
    a = {1'b0, vin[k*6 +: 5]};
    return tt_m[k][a];
  endfunction

  function automatic logic comb_m(int k, logic [23:0] vin, logic [3:0] vb);
    logic w0, w2, w1, w;
    w0 = vb[0] ? r6m(1, vin) : r6m(0, vin);
    w2 = vb[2] ? r6m(3, vin) : r6m(2, vin);
    w1 = vb[1] ? w2 : w0;
    w  = (k == 0) ? w0 : (k == 2) ? w2 : w1;
    case (src_m[k])
      2'd0:    return r6m(k, vin);
      2'd1:    return r5m(k, vin);
      2'd2:    return w;
      default: return vb[k];
    endcase
  endfunction

  task automatic load_cfg();
    logic [267:0] nv;
    for (int k = 0; k < 4; k++) begin
      nv[k*64 +: 64]  = tt_m[k];
      nv[256 + 3*k +: 3] = {ureg_m[k], src_m[k]};
    end
    for (int i = 267; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_in = nv[i]; clk_en = 1'b0; sync_clr = 1'b0;
      #2;
      chk({3'b0, cfg_out}, {3'b0, cfg_old[i]}, "R10 chain readback");
      chk(path_out, 4'b0, "R9 path_out quiet");
      chk(o5_out, 4'b0, "R9 o5_out quiet");
    end
    @(negedge clk);
    cfg_en = 1'b0;
    for (int k = 0; k < 4; k++) q_m[k] = 1'b0;
    cfg_old = nv;
  endtask

  task automatic step(input logic [23:0] vin, input logic [3:0] vb,
                      input logic vce, input logic vclr, input string tag);
    logic [3:0] cv, eo, e5;
    @(negedge clk);
    lut_in = vin; bypass = vb; clk_en = vce; sync_clr = vclr; cfg_en = 1'b0;
    #2;
    for (int k = 0; k < 4; k++) begin
      cv[k] = comb_m(k, vin, vb);
      eo[k] = ureg_m[k] ? q_m[k] : cv[k];
      e5[k] = r5m(k, vin);
    end
    chk(path_out, eo, tag);
    chk(o5_out, e5, "R2 o5_out");
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      if (vclr)     q_m[k] = 1'b0;
      else if (vce) q_m[k] = cv[k];
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_in = 1'b0; clk_en = 1'b0; sync_clr = 1'b0;
    lut_in = '0; bypass = '0;
    cfg_old = '0;
    for (int k = 0; k < 4; k++) begin
      tt_m[k] = '0; src_m[k] = '0; ureg_m[k] = 1'b0; q_m[k] = 1'b0;
    end
    #35;
    // R11: reset state
    chk(path_out, 4'b0, "R11 reset path_out");
    chk(o5_out, 4'b0, "R11 reset o5_out");
    chk({3'b0, cfg_out}, 4'b0, "R11 reset cfg_out");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2: plain 6-input tables, exhaustive sweep
    for (int k = 0; k < 4; k++) begin
      tt_m[k] = {$urandom(), $urandom()}; src_m[k] = 2'd0; ureg_m[k] = 1'b0;
    end
    load_cfg();
    for (int a = 0; a < 64; a++)
      step({6'(a + 51), 6'(a + 34), 6'(a + 17), 6'(a)}, 4'($urandom()), 1'b0, 1'b0,
           "R1 six-input result");

    // R3 / R4 / R5: wide functions and 5-input source
    for (int k = 0; k < 4; k++) tt_m[k] = {$urandom(), $urandom()};
    src_m[0] = 2'd2; src_m[1] = 2'd2; src_m[2] = 2'd2; src_m[3] = 2'd1;
    load_cfg();
    for (int i = 0; i < 256; i++)
      step(24'($urandom()), 4'(i), 1'b0, 1'b0, "R3 R4 R5 wide select");

    // R6 / R7 / R8 / R9: registered paths and standalone register
    for (int k = 0; k < 4; k++) begin
      tt_m[k] = {$urandom(), $urandom()}; ureg_m[k] = 1'b1;
    end
    src_m[0] = 2'd0; src_m[1] = 2'd3; src_m[2] = 2'd2; src_m[3] = 2'd1;
    load_cfg();
    step(24'($urandom()), 4'hf, 1'b0, 1'b0, "R9 flops cleared by load");
    for (int i = 0; i < 300; i++)
      step(24'($urandom()), 4'($urandom()), 1'($urandom()), ($urandom_range(9) == 0),
           "R6 R7 R8 registered");
    step(24'($urandom()), 4'hf, 1'b1, 1'b0, "R7 capture");
    step(24'($urandom()), 4'hf, 1'b1, 1'b1, "R8 clear over enable");
    step(24'($urandom()), 4'h0, 1'b0, 1'b0, "R8 cleared value");

    // R5 / R6: mixed modes
    for (int k = 0; k < 4; k++) begin
      tt_m[k] = {$urandom(), $urandom()};
      src_m[k] = 2'($urandom_range(3)); ureg_m[k] = 1'($urandom());
    end
    load_cfg();
    for (int i = 0; i < 300; i++)
      step(24'($urandom()), 4'($urandom()), 1'($urandom()), ($urandom_range(15) == 0),
           "R5 R6 mixed modes");

    // R11: asynchronous reset mid-run
    @(negedge clk);
    #5 rst_n = 1'b0;
    #1;
    chk(path_out, 4'b0, "R11 async path_out");
    chk(o5_out, 4'b0, "R11 async o5_out");
    chk({3'b0, cfg_out}, 4'b0, "R11 async cfg_out");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule